// File: doc/BRIEF.md
# Per-Drive Perpendicular Recording Mode Controller

This block stores the state that a floppy controller's perpendicular-mode command writes. It keeps two global mode bits (write-gate early and gap-size select), one perpendicular flag for each attached drive, and an overwrite-enable qualifier that guards those flags. For the drive currently selected, it works out three things: the effective recording mode, the number of Gap2 bytes written ahead of the sync field, and the write precompensation value handed to the precompensation delay line.

The global bits take priority over the per-drive flags. While both global bits are clear, a drive whose flag is set is treated as perpendicular automatically, at a density that follows the programmed data rate. Such a drive gets zero precompensation. A software reset clears only the global bits. A hardware reset clears everything. The command byte sequencing and the delay line sit outside this block.

Top module: `perp_mode_ctl`

## Requirements
- R1: `mode_o` encodes 0 = conventional, 1 = perpendicular at the 500 Kbps density class, 2 = perpendicular at the 1 Mbps density class; the value 3 never appears.
- R2: With WGATE=1 and GAP=1 every drive resolves to mode 2. With WGATE=1 and GAP=0 every drive resolves to mode 1. With WGATE=0 and GAP=1 every drive resolves to mode 0. Whenever either global bit is 1, the per-drive flags have no effect on any output.
- R3: With both global bits 0, the selected drive resolves to mode 0 when its flag is 0. When its flag is 1 it resolves to mode 2 if `rate_i` is 2'b11, and to mode 1 for any other rate code.
- R4: `precomp_o` is 0 while the selected drive is perpendicular through its own flag (R3). In every other case it equals `precomp_i`.
- R5: `gap2_bytes_o` is 38 in mode 2, 19 in mode 1 and 0 in mode 0.
- R6: `vco_lead_o` is 43 in mode 2 and 24 in modes 0 and 1.
- R7: The command byte uses these bits: bit 0 = WGATE, bit 1 = GAP, bits 5:2 = flags for drives 0 to 3, bit 7 = overwrite enable. Bit 6 is unused. On each command write, WGATE and GAP load from the byte, and the outputs reflect them from the cycle after the write strobe.
- R8: The drive flags load from bits 5:2 only on a command write whose bit 7 is 1. Otherwise they keep their value.
- R9: A software reset pulse clears WGATE and GAP at the next clock edge and leaves the drive flags unchanged. When it coincides with a command write, the clear wins for WGATE and GAP, and the flags still follow R8.
- R10: Hardware reset (`rst_n` low, asynchronous) clears WGATE, GAP and all drive flags, so every drive is conventional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| srst_i | input | 1 | Software reset pulse, one cycle |
| cmd_we_i | input | 1 | Command parameter byte write strobe |
| cmd_byte_i | input | 8 | Command parameter byte |
| drv_sel_i | input | 2 | Selected drive |
| rate_i | input | 2 | Programmed data-rate code, 2'b11 = 1 Mbps |
| precomp_i | input | 3 | Programmed write precompensation code |
| mode_o | output | 2 | Effective recording mode of the selected drive |
| precomp_o | output | 3 | Precompensation to apply to the selected drive |
| gap2_bytes_o | output | 6 | Gap2 bytes written before the sync field |
| vco_lead_o | output | 6 | Byte count into Gap2 at which the read PLL starts |

## Verification
The register assertions assume that a software reset pulse and a command write are each sampled as a single clock-synchronous event. The bench holds both strobes for exactly one cycle and changes them only on the falling edge. The output assertions assume that the drive select and rate code stay steady around the rising edge. The sweep therefore changes those inputs only at the falling edge and samples one time unit later. The drive select always names one of the four drives, so the out-of-range path is never exercised.

// File: rtl/perp_pkg.sv
package perp_pkg;

  typedef enum logic [1:0] {
    RM_CONV = 2'd0,
    RM_P500 = 2'd1,
    RM_P1M  = 2'd2
  } rec_mode_e;

  localparam logic [1:0] RATE_CODE_1M = 2'b11;
  localparam int unsigned GAP2_BYTES_500K = 19;
  localparam int unsigned GAP2_BYTES_1M   = 38;
  localparam int unsigned VCO_LEAD_BASE   = 24;
  localparam int unsigned VCO_LEAD_1M     = 43;

  // Global bits: WGATE selects perpendicular, GAP picks the 1 Mbps class.
  function automatic rec_mode_e global_mode(input logic wg, input logic gp);
    if (!wg) return RM_CONV;
    return gp ? RM_P1M : RM_P500;
  endfunction

  // Density class for a drive made perpendicular through its own flag.
  function automatic rec_mode_e rate_mode(input logic [1:0] rate);
    return (rate == RATE_CODE_1M) ? RM_P1M : RM_P500;
  endfunction

  function automatic logic [5:0] gap2_len(input rec_mode_e m);
    case (m)
      RM_P1M:  return 6'(GAP2_BYTES_1M);
      RM_P500: return 6'(GAP2_BYTES_500K);
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [5:0] vco_lead(input rec_mode_e m);
    return (m == RM_P1M) ? 6'(VCO_LEAD_1M) : 6'(VCO_LEAD_BASE);
  endfunction

endpackage

// File: rtl/perp_cmd_regs.sv
module perp_cmd_regs #(
  parameter int NDRV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst_i,
  input  logic            cmd_we_i,
  input  logic [7:0]      cmd_byte_i,
  output logic            wgate_o,
  output logic            gap_o,
  output logic [NDRV-1:0] dflags_o
);
  localparam int BIT_WG  = 0;
  localparam int BIT_GAP = 1;
  localparam int BIT_D0  = 2;
  localparam int BIT_OW  = 7;

  logic            wgate_q, gap_q;
  logic [NDRV-1:0] dflags_q;

  // Named events for the assertions below.
  logic glob_load, glob_clear, flag_load;
  assign glob_clear = srst_i;
  assign glob_load  = cmd_we_i && !srst_i;
  assign flag_load  = cmd_we_i && cmd_byte_i[BIT_OW];

  logic unused_bits;
  assign unused_bits = ^cmd_byte_i[BIT_OW-1:BIT_D0+NDRV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgate_q  <= 1'b0;
      gap_q    <= 1'b0;
      dflags_q <= '0;
    end else begin
      if (glob_clear) begin
        wgate_q <= 1'b0;
        gap_q   <= 1'b0;
      end else if (glob_load) begin
        wgate_q <= cmd_byte_i[BIT_WG];
        gap_q   <= cmd_byte_i[BIT_GAP];
      end
      if (flag_load) dflags_q <= cmd_byte_i[BIT_D0 +: NDRV];
    end
  end

  assign wgate_o  = wgate_q;
  assign gap_o    = gap_q;
  assign dflags_o = dflags_q;

  AST_SRST_CLEARS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (!wgate_q && !gap_q)); // R9
  AST_SRST_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_i && !cmd_we_i) |=> $stable(dflags_q)); // R9
  AST_NO_OW_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && !cmd_byte_i[BIT_OW]) |=> $stable(dflags_q)); // R8
  AST_OW_LOADS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_byte_i[BIT_OW]) |=> (dflags_q == $past(cmd_byte_i[BIT_D0 +: NDRV]))); // R8
  AST_GLOBAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && !srst_i) |=> (wgate_q == $past(cmd_byte_i[BIT_WG]) &&
                                gap_q == $past(cmd_byte_i[BIT_GAP]))); // R7
  AST_GLOBAL_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we_i && !srst_i) |=> $stable({wgate_q, gap_q})); // R7
  AST_HW_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dflags_q == '0 && !wgate_q && !gap_q)); // R10

endmodule

// File: rtl/perp_resolve.sv
module perp_resolve
  import perp_pkg::*;
#(
  parameter int NDRV = 4,
  parameter int PCW  = 3,
  localparam int DSW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            wgate_i,
  input  logic            gap_i,
  input  logic [NDRV-1:0] dflags_i,
  input  logic [DSW-1:0]  drv_sel_i,
  input  logic [1:0]      rate_i,
  input  logic [PCW-1:0]  precomp_i,
  output rec_mode_e       mode_o,
  output logic            dpath_perp_o,
  output logic [PCW-1:0]  precomp_o
);
  logic global_on;
  logic sel_flag;

  assign global_on = wgate_i || gap_i;
  assign sel_flag  = (int'(drv_sel_i) < NDRV) ? dflags_i[drv_sel_i] : 1'b0;

  // Per-drive flag only counts while both global bits are clear.
  assign dpath_perp_o = !global_on && sel_flag;

  always_comb begin
    if (global_on)         mode_o = global_mode(wgate_i, gap_i);
    else if (dpath_perp_o) mode_o = rate_mode(rate_i);
    else                   mode_o = RM_CONV;
  end

  assign precomp_o = dpath_perp_o ? '0 : precomp_i;

endmodule

// File: rtl/perp_timing.sv
module perp_timing
  import perp_pkg::*;
(
  input  rec_mode_e  mode_i,
  output logic [5:0] gap2_bytes_o,
  output logic [5:0] vco_lead_o
);
  assign gap2_bytes_o = gap2_len(mode_i);
  assign vco_lead_o   = vco_lead(mode_i);
endmodule

// File: rtl/perp_mode_ctl.sv
module perp_mode_ctl
  import perp_pkg::*;
#(
  parameter int NDRV = 4,
  parameter int PCW  = 3,
  localparam int DSW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst_i,
  input  logic           cmd_we_i,
  input  logic [7:0]     cmd_byte_i,
  input  logic [DSW-1:0] drv_sel_i,
  input  logic [1:0]     rate_i,
  input  logic [PCW-1:0] precomp_i,
  output logic [1:0]     mode_o,
  output logic [PCW-1:0] precomp_o,
  output logic [5:0]     gap2_bytes_o,
  output logic [5:0]     vco_lead_o
);
  logic            wgate, gap;
  logic [NDRV-1:0] dflags;
  rec_mode_e       mode;
  logic            dpath_perp;

  perp_cmd_regs #(.NDRV(NDRV)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_i     (srst_i),
    .cmd_we_i   (cmd_we_i),
    .cmd_byte_i (cmd_byte_i),
    .wgate_o    (wgate),
    .gap_o      (gap),
    .dflags_o   (dflags)
  );

  perp_resolve #(.NDRV(NDRV), .PCW(PCW)) u_resolve (
    .wgate_i      (wgate),
    .gap_i        (gap),
    .dflags_i     (dflags),
    .drv_sel_i    (drv_sel_i),
    .rate_i       (rate_i),
    .precomp_i    (precomp_i),
    .mode_o       (mode),
    .dpath_perp_o (dpath_perp),
    .precomp_o    (precomp_o)
  );

  perp_timing u_timing (
    .mode_i       (mode),
    .gap2_bytes_o (gap2_bytes_o),
    .vco_lead_o   (vco_lead_o)
  );

  assign mode_o = mode;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3); // R1
  AST_GLOBAL_1M_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wgate && gap) |-> (mode_o == 2'd2)); // R2
  AST_GAP_ONLY_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (!wgate && gap) |-> (mode_o == 2'd0 && precomp_o == precomp_i)); // R2
  AST_FLAG_ZERO_PRECOMP: assert property (@(posedge clk) disable iff (!rst_n)
    dpath_perp |-> (precomp_o == '0)); // R4
  AST_OTHER_PRECOMP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !dpath_perp |-> (precomp_o == precomp_i)); // R4
  AST_CONV_NO_GAP2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (gap2_bytes_o == 6'd0 && vco_lead_o == 6'd24)); // R5

endmodule

// File: tb/tb_perp_mode_ctl.sv
module tb_perp_mode_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst_i = 1'b0;
  logic       cmd_we_i = 1'b0;
  logic [7:0] cmd_byte_i = '0;
  logic [1:0] drv_sel_i = '0;
  logic [1:0] rate_i = '0;
  logic [2:0] precomp_i = '0;
  logic [1:0] mode_o;
  logic [2:0] precomp_o;
  logic [5:0] gap2_bytes_o;
  logic [5:0] vco_lead_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perp_mode_ctl dut (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_i), .cmd_we_i(cmd_we_i),
    .cmd_byte_i(cmd_byte_i), .drv_sel_i(drv_sel_i), .rate_i(rate_i),
    .precomp_i(precomp_i), .mode_o(mode_o), .precomp_o(precomp_o),
    .gap2_bytes_o(gap2_bytes_o), .vco_lead_o(vco_lead_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(input bit g, input bit w, input bit [3:0] f,
                                  input int d, input int r);
    if (g || w) return w ? (g ? 2 : 1) : 0;
    if (f[d]) return (r == 3) ? 2 : 1;
    return 0;
  endfunction

  // Byte: {ow, unused, flags[3:0], gap, wgate}
  task automatic write_cmd(input bit ow, input bit [3:0] f, input bit g, input bit w);
    @(negedge clk);
    cmd_we_i = 1'b1;
    cmd_byte_i = {ow, 1'b0, f, g, w};
    @(negedge clk);
    cmd_we_i = 1'b0;
  endtask

  task automatic probe(input int d, input int r, input int pc, input int em, input int epc,
                       input string tag);
    drv_sel_i = 2'(d);
    rate_i = 2'(r);
    precomp_i = 3'(pc);
    #1;
    check({tag, " mode"}, int'(mode_o), em);
    check({tag, " precomp"}, int'(precomp_o), epc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: after hardware reset all drives conventional, precomp passes
    for (int d = 0; d < 4; d++) probe(d, 3, 5, 0, 5, "R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 4; d++) probe(d, 3, 6, 0, 6, "R10 after release");

    // Sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int f = 0; f < 16; f++) begin
      for (int gw = 0; gw < 4; gw++) begin
        bit g, w;
        g = gw[1];
        w = gw[0];
        write_cmd(1'b1, 4'(f), g, w);
        for (int d = 0; d < 4; d++) begin
          for (int r = 0; r < 4; r++) begin
            int pc, em, epc;
            pc = (d * 3 + r + f + 1) % 8;
            em = exp_mode(g, w, 4'(f), d, r);
            epc = (!(g || w) && f[d]) ? 0 : pc;
            probe(d, r, pc, em, epc, "R2/R3/R4/R7/R8 sweep");
            check("R1 mode legal", int'(mode_o != 2'd3), 1);
            check("R5 gap2 bytes", int'(gap2_bytes_o), em * 19);
            check("R6 vco lead", int'(vco_lead_o), 24 + ((em == 2) ? 19 : 0));
          end
        end
      end
    end

    // R9: software reset clears globals, flags kept (flags 1010, globals 11)
    write_cmd(1'b1, 4'b1010, 1'b1, 1'b1);
    probe(0, 0, 4, 2, 4, "R2 global 1M before srst");
    @(negedge clk);
    srst_i = 1'b1;
    @(negedge clk);
    srst_i = 1'b0;
    probe(1, 0, 4, 1, 0, "R9 srst keeps D1");
    probe(3, 3, 4, 2, 0, "R9 srst keeps D3");
    probe(0, 3, 4, 0, 4, "R9 srst D0 clear");

    // R9: srst with same-cycle command: globals cleared, flags load 0101
    @(negedge clk);
    srst_i = 1'b1;
    cmd_we_i = 1'b1;
    cmd_byte_i = {1'b1, 1'b0, 4'b0101, 1'b1, 1'b1};
    @(negedge clk);
    srst_i = 1'b0;
    cmd_we_i = 1'b0;
    probe(0, 3, 7, 2, 0, "R9 srst+cmd D0 loaded");
    probe(1, 3, 7, 0, 7, "R9 srst+cmd D1 loaded");

    // R8: OW=0 leaves flags unchanged
    write_cmd(1'b0, 4'b1010, 1'b0, 1'b0);
    probe(1, 1, 3, 0, 3, "R8 no OW D1 held");
    probe(2, 1, 3, 1, 0, "R8 no OW D2 held");

    // R2: GAP only -> conventional, flags ignored
    write_cmd(1'b0, 4'b0000, 1'b1, 1'b0);
    probe(0, 3, 2, 0, 2, "R2 gap-only conventional");
    check("R5 gap2 gap-only", int'(gap2_bytes_o), 0);

    // R10: hardware reset mid-run clears flags
    write_cmd(1'b1, 4'b1111, 1'b0, 1'b0);
    probe(3, 0, 1, 1, 0, "R10 flags set pre-reset");
    rst_n = 1'b0;
    #2;
    probe(3, 0, 1, 0, 1, "R10 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 4; d++) probe(d, 3, 1, 0, 1, "R10 all conventional");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule